// File: doc/BRIEF.md
# Memory-Mapped GPIO and Interrupt Expander

This block hangs off a host processor's simple synchronous parallel bus. It provides banks of pin registers and one event register. A bank register packs a group of pins into one word. Writing the word sets the levels of the pins that are built as outputs. Reading it returns the held level of each output pin and the live level of each input pin. Pin directions and the reset levels of the outputs are fixed when the block is built.

Up to sixteen event inputs are synchronised and watched for rising edges. Each edge sets a sticky pending bit. The pending bits can be read from a single status register. The same register also clears them: the host writes a fixed acknowledge word to it, all ones by default, or all zeros when the inverted-acknowledge option is chosen. Writing any other word has no effect on it. The block has no masking. Any pending bit raises the single registered summary line, which the host treats as rising-edge sensitive. For that reason the line is pulled low for a cycle after every acknowledge, so any event still pending gives the host a fresh edge.

Top module: `gpio_irq_expander`

## Requirements
- R1: Register index i sits at byte address i<<1 on a 16-bit bus (BUS_W=16) and i<<2 on a 32-bit bus. A read of a byte address whose low shift bits are not zero returns 0, and so does a read of an index that maps to nothing.
- R2: Pin p is held in register BANK0_IDX + (p / BANK_PINS)*(BANK_PINS/REG_W) + (p mod BANK_PINS)/REG_W, at bit p mod REG_W. With the defaults (REG_W=8, 16 pins per bank, BANK0_IDX=0), this is register p/8, bit p mod 8.
- R3: A bank write replaces every output-direction pin of that register with the written bit. Pins built as inputs (OUT_DIR bit 0) always drive 0 on pin_out.
- R4: A read of a bank register returns the latched level for output pins and the live pin_in level for input pins, zero-extended to 16 bits. rdata is valid in the cycle after the read strobe and is 0 when no read took place.
- R5: After reset, pin_out equals OUT_INIT masked by OUT_DIR, irq_out is 0, and no event is pending.
- R6: A rising edge on evt_in[k] sets pending bit k. The bit stays set until an acknowledge. Falling edges set nothing. The status register (index ACK_IDX=4) reads the pending bits in bits N_IRQ-1..0, with the bits above them 0.
- R7: Writing the acknowledge word (16'hFFFF, or 16'h0000 when INV_ACK=1) to the status register clears all pending bits. Any other word written there leaves them unchanged.
- R8: A rising edge that reaches the pending logic in the same cycle as an acknowledge stays pending.
- R9: irq_out goes to 1 in the cycle after any bit is pending, whatever the source. No source can be masked.
- R10: In the cycle after an acknowledge, irq_out is 0 even if events remain pending. It then rises again if anything is still pending.
- R11: Writes with an unaligned byte address, or to an index that maps to nothing, change no pin and no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, qualified by cs |
| re | input | 1 | Read strobe, qualified by cs |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | N_BANKS*BANK_PINS | Live pin levels |
| pin_out | output | N_BANKS*BANK_PINS | Driven output pin levels |
| evt_in | input | N_IRQ | Asynchronous event inputs |
| irq_out | output | 1 | Summary interrupt |

## Verification
The assertions assume that cs, we, addr and wdata are stable around the rising clock edge. The bench drives them only on falling edges. The properties on the pending bits also assume that an event input holds each level for at least two cycles, so that the synchroniser delivers every edge. The random phase holds each event pattern for several cycles before it samples the status register. The case where an edge meets an acknowledge is placed in a directed sequence: the bench counts the clock edges through the synchroniser so that the acknowledge lands in the exact cycle the edge is latched.

// File: rtl/gx_pkg.sv
package gx_pkg;
   localparam int unsigned DATA_W = 16;

   function automatic int unsigned addr_shift(input int unsigned bus_w);
      return (bus_w == 32) ? 2 : 1;
   endfunction

   function automatic logic [DATA_W-1:0] ack_word(input bit inverted);
      return inverted ? 16'h0000 : 16'hFFFF;
   endfunction
endpackage

// File: rtl/gx_addr_dec.sv
module gx_addr_dec #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ASH    = 1,
   localparam int unsigned IDX_W = ADDR_W - ASH
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              aligned,
   output logic [IDX_W-1:0]  idx
);
   assign aligned = (addr[ASH-1:0] == '0);
   assign idx     = addr[ADDR_W-1:ASH];
endmodule

// File: rtl/gx_bank.sv
module gx_bank #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned PINS  = 16,
   parameter int unsigned IDX_W = 7,
   parameter int unsigned BASE  = 0,
   parameter logic [PINS-1:0] DIR  = '0,
   parameter logic [PINS-1:0] INIT = '0,
   localparam int unsigned NREG = PINS / REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [REG_W-1:0] wdata,
   input  logic [PINS-1:0]  pin_in,
   output logic [PINS-1:0]  pin_out,
   output logic [REG_W-1:0] rd_word
);
   localparam logic [IDX_W-1:0] BASE_L = IDX_W'(BASE);
   localparam logic [IDX_W-1:0] END_L  = IDX_W'(BASE + NREG);

   logic [PINS-1:0]  latch_q;
   logic [PINS-1:0]  view;
   logic             hit;
   logic [IDX_W-1:0] sel;

   assign hit  = (idx >= BASE_L) && (idx < END_L);
   assign sel  = idx - BASE_L;
   assign view = (latch_q & DIR) | (pin_in & ~DIR);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            latch_q[r*REG_W +: REG_W] <= INIT[r*REG_W +: REG_W] & DIR[r*REG_W +: REG_W];
         else if (wr && hit && sel == IDX_W'(r))
            latch_q[r*REG_W +: REG_W] <= wdata & DIR[r*REG_W +: REG_W];
      end
   end

   always_comb begin
      rd_word = '0;
      for (int r = 0; r < NREG; r++)
         if (hit && sel == IDX_W'(r))
            rd_word = view[r*REG_W +: REG_W];
   end

   assign pin_out = latch_q;
endmodule

// File: rtl/gx_irq_capture.sv
module gx_irq_capture #(
   parameter int unsigned N_IRQ = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] evt_in,
   input  logic             ack,
   output logic [N_IRQ-1:0] pending,
   output logic [N_IRQ-1:0] edges,
   output logic             summary
);
   logic [N_IRQ-1:0] sync0_q, sync1_q, prev_q, pend_q;
   logic             sum_q;

   assign edges = sync1_q & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync0_q <= '0;
         sync1_q <= '0;
         prev_q  <= '0;
         pend_q  <= '0;
         sum_q   <= 1'b0;
      end else begin
         sync0_q <= evt_in;
         sync1_q <= sync0_q;
         prev_q  <= sync1_q;
         pend_q  <= ack ? edges : (pend_q | edges);
         sum_q   <= ack ? 1'b0 : (|pend_q);
      end
   end

   assign pending = pend_q;
   assign summary = sum_q;
endmodule

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander
   import gx_pkg::*;
#(
   parameter int unsigned BUS_W     = 16,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned N_BANKS   = 2,
   parameter int unsigned BANK_PINS = 16,
   parameter int unsigned BANK0_IDX = 0,
   parameter int unsigned ACK_IDX   = 4,
   parameter int unsigned N_IRQ     = 12,
   parameter bit          INV_ACK   = 1'b0,
   parameter logic [N_BANKS*BANK_PINS-1:0] OUT_DIR  = 32'h0FF0_F00F,
   parameter logic [N_BANKS*BANK_PINS-1:0] OUT_INIT = 32'h0A50_3005
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cs,
   input  logic                           we,
   input  logic                           re,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [15:0]                    wdata,
   output logic [15:0]                    rdata,
   input  logic [N_BANKS*BANK_PINS-1:0]   pin_in,
   output logic [N_BANKS*BANK_PINS-1:0]   pin_out,
   input  logic [N_IRQ-1:0]               evt_in,
   output logic                           irq_out
);
   localparam int unsigned ASH     = addr_shift(BUS_W);
   localparam int unsigned IDX_W   = ADDR_W - ASH;
   localparam int unsigned REGS_PB = BANK_PINS / REG_W;
   localparam int unsigned BANKS_END = BANK0_IDX + N_BANKS * REGS_PB;
   localparam logic [IDX_W-1:0] ACK_L = IDX_W'(ACK_IDX);
   localparam logic [DATA_W-1:0] ACK_VAL = ack_word(INV_ACK);

   if (!(BUS_W == 16 || BUS_W == 32)) begin : g_bad_bus
      $error("BUS_W must be 16 or 32");
   end
   if (!(REG_W == 8 || REG_W == 16)) begin : g_bad_reg
      $error("REG_W must be 8 or 16");
   end
   if (N_IRQ < 1 || N_IRQ > 16) begin : g_bad_irq
      $error("N_IRQ must be 1..16");
   end
   if (BANK_PINS % REG_W != 0) begin : g_bad_pins
      $error("BANK_PINS must be a multiple of REG_W");
   end
   if (ACK_IDX >= BANK0_IDX && ACK_IDX < BANKS_END) begin : g_bad_ack
      $error("ACK_IDX overlaps the bank registers");
   end
   if (BANKS_END >= (1 << IDX_W)) begin : g_bad_span
      $error("register span exceeds address width");
   end

   logic              aligned;
   logic [IDX_W-1:0]  idx;
   logic              wr_any, ack_hit;
   logic [N_IRQ-1:0]  pend_q, irq_edge;
   logic [REG_W-1:0]  bank_rd [N_BANKS];
   logic [REG_W-1:0]  bank_any;
   logic [15:0]       rdata_q;

   gx_addr_dec #(.ADDR_W(ADDR_W), .ASH(ASH)) u_dec (
      .addr    (addr),
      .aligned (aligned),
      .idx     (idx)
   );

   assign wr_any  = cs && we && aligned;
   assign ack_hit = wr_any && (idx == ACK_L) && (wdata == ACK_VAL);

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      gx_bank #(
         .REG_W (REG_W),
         .PINS  (BANK_PINS),
         .IDX_W (IDX_W),
         .BASE  (BANK0_IDX + b * REGS_PB),
         .DIR   (OUT_DIR[b*BANK_PINS +: BANK_PINS]),
         .INIT  (OUT_INIT[b*BANK_PINS +: BANK_PINS])
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr_any),
         .idx     (idx),
         .wdata   (wdata[REG_W-1:0]),
         .pin_in  (pin_in[b*BANK_PINS +: BANK_PINS]),
         .pin_out (pin_out[b*BANK_PINS +: BANK_PINS]),
         .rd_word (bank_rd[b])
      );
   end

   always_comb begin
      bank_any = '0;
      for (int b = 0; b < N_BANKS; b++)
         bank_any = bank_any | bank_rd[b];
   end

   gx_irq_capture #(.N_IRQ(N_IRQ)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_in  (evt_in),
      .ack     (ack_hit),
      .pending (pend_q),
      .edges   (irq_edge),
      .summary (irq_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (cs && re && aligned)
         rdata_q <= (idx == ACK_L) ? 16'(pend_q) : 16'(bank_any);
      else
         rdata_q <= '0;
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/gx_expander_chk.sv
module gx_expander_chk #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned ASH     = 1,
   parameter int unsigned ACK_IDX = 4,
   parameter int unsigned NPIN    = 32,
   parameter int unsigned N_IRQ   = 12,
   parameter logic [15:0] ACK_VAL = 16'hFFFF,
   parameter logic [NPIN-1:0] OUT_DIR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [15:0]       wdata,
   input logic [NPIN-1:0]   pin_out,
   input logic              irq_out,
   input logic [N_IRQ-1:0]  pending,
   input logic [N_IRQ-1:0]  edges
);
   localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(ACK_IDX << ASH);
   logic ack_seen;
   assign ack_seen = cs && we && (addr == ACK_ADDR) && (wdata == ACK_VAL);

   a_r3_inputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~OUT_DIR) == '0);

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_seen |=> ((pending & $past(pending)) == $past(pending)));

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_seen |=> ((pending & ~$past(edges)) == '0));

   a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ack_seen |=> ((pending & $past(edges)) == $past(edges)));

   a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_seen && (|pending)) |=> irq_out);

   a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack_seen |=> !irq_out);

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && we) |=> $stable(pin_out));
endmodule

bind gpio_irq_expander gx_expander_chk #(
   .ADDR_W  (ADDR_W),
   .ASH     (ASH),
   .ACK_IDX (ACK_IDX),
   .NPIN    (N_BANKS*BANK_PINS),
   .N_IRQ   (N_IRQ),
   .ACK_VAL (ACK_VAL),
   .OUT_DIR (OUT_DIR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs      (cs),
   .we      (we),
   .addr    (addr),
   .wdata   (wdata),
   .pin_out (pin_out),
   .irq_out (irq_out),
   .pending (pend_q),
   .edges   (irq_edge)
);

// File: tb/test_gpio_irq_expander.sv
module test_gpio_irq_expander;
   localparam logic [31:0] DIR  = 32'h0FF0_F00F;
   localparam logic [31:0] INIT = 32'h0A50_3005;
   localparam int NIRQ = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 0, we = 0, re = 0;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [NIRQ-1:0] evt_in = '0;
   logic        irq_out;

   int checks = 0, fails = 0;
   logic [31:0]     exp_lat;
   logic [NIRQ-1:0] exp_pend;
   logic [15:0]     rd;

   always #2.5 clk = ~clk;

   gpio_irq_expander i_gpio_irq_expander (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .evt_in(evt_in), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input int i);
      logic [31:0] v = (exp_lat & DIR) | (pin_in & ~DIR);
      return 16'(v[i*8 +: 8]);
   endfunction

   function automatic logic [31:0] apply_write(input logic [31:0] lat, input int i, input logic [7:0] d);
      logic [31:0] n = lat;
      for (int k = 0; k < 8; k++)
         if (DIR[i*8+k]) n[i*8+k] = d[k];
      return n;
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
      @(negedge clk); cs = 0; we = 0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [15:0] q);
      @(negedge clk); cs = 1; re = 1; addr = a;
      @(negedge clk); cs = 0; re = 0; q = rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      exp_lat  = INIT & DIR;
      exp_pend = '0;
      settle(4);
      rst_n = 1'b1;
      settle(1);
      // R5 reset state
      chk("R5 pin_out reset", pin_out, INIT & DIR);
      chk("R5 irq_out reset", {31'b0, irq_out}, 0);
      bus_read(8'd8, rd);
      chk("R5 no pending after reset", rd, 0);

      // R2/R4 directed: register 1 of bank 0 covers pins 8..15
      pin_in = 32'hA5C3_3C5A;
      bus_read(8'd2, rd);
      chk("R2 R4 reg1 read", rd, exp_word(1));
      settle(1);
      chk("R4 rdata zero when idle", rdata, 0);

      // R1 misaligned and unmapped reads
      bus_read(8'd1, rd);
      chk("R1 misaligned read zero", rd, 0);
      bus_read(8'd10, rd);
      chk("R1 unmapped read zero", rd, 0);

      // R11 ignored writes
      bus_write(8'd3, 16'h00FF);
      chk("R11 misaligned write ignored", pin_out, exp_lat);
      bus_write(8'd12, 16'h00FF);
      chk("R11 unmapped write ignored", pin_out, exp_lat);

      // R3 directed: all ones to reg 3 (pins 24..31)
      bus_write(8'd6, 16'hFFFF);
      exp_lat = apply_write(exp_lat, 3, 8'hFF);
      chk("R3 write all ones", pin_out, exp_lat);

      // random bank traffic
      for (int n = 0; n < 200; n++) begin
         int op = $urandom_range(0, 2);
         int i  = $urandom_range(0, 3);
         if (op == 0) begin
            logic [7:0] d = 8'($urandom);
            bus_write(8'(i << 1), {8'($urandom), d});
            exp_lat = apply_write(exp_lat, i, d);
            chk("R3 pin_out after write", pin_out, exp_lat);
         end else begin
            if (op == 1) pin_in = $urandom;
            bus_read(8'(i << 1), rd);
            chk("R4 R2 bank read", rd, exp_word(i));
         end
      end

      // R6 directed: rising edges latch, falling edges do not
      evt_in = 12'h005;
      settle(6);
      exp_pend = 12'h005;
      bus_read(8'd8, rd);
      chk("R6 pending after edge", rd, 16'(exp_pend));
      chk("R9 irq_out high", {31'b0, irq_out}, 1);
      evt_in = 12'h000;
      settle(6);
      bus_read(8'd8, rd);
      chk("R6 falling edge keeps state", rd, 16'(exp_pend));

      // R7 non-ack word ignored, ack clears
      bus_write(8'd8, 16'h1234);
      bus_read(8'd8, rd);
      chk("R7 non-ack write ignored", rd, 16'(exp_pend));
      bus_write(8'd8, 16'hFFFF);
      exp_pend = '0;
      chk("R10 irq_out low after ack", {31'b0, irq_out}, 0);
      bus_read(8'd8, rd);
      chk("R7 ack clears", rd, 0);
      chk("R9 irq_out idle", {31'b0, irq_out}, 0);

      // R8/R10: edge arriving on the ack cycle
      @(negedge clk); evt_in = 12'h800;
      @(posedge clk); @(posedge clk);
      @(negedge clk); cs = 1; we = 1; addr = 8'd8; wdata = 16'hFFFF;
      @(negedge clk); cs = 0; we = 0;
      chk("R10 forced low on ack", {31'b0, irq_out}, 0);
      @(negedge clk);
      chk("R10 fresh rise after ack", {31'b0, irq_out}, 1);
      exp_pend = 12'h800;
      bus_read(8'd8, rd);
      chk("R8 edge on ack kept", rd, 16'(exp_pend));

      // random event traffic
      for (int n = 0; n < 60; n++) begin
         logic [NIRQ-1:0] nv = NIRQ'($urandom);
         exp_pend = exp_pend | (nv & ~evt_in);
         evt_in = nv;
         settle(6);
         bus_read(8'd8, rd);
         chk("R6 random pending", rd, 16'(exp_pend));
         chk("R9 random summary", {31'b0, irq_out}, {31'b0, |exp_pend});
         if ($urandom_range(0, 2) == 0) begin
            bus_write(8'd8, 16'hFFFF);
            exp_pend = '0;
            chk("R10 random ack low", {31'b0, irq_out}, 0);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule